// File: doc/BRIEF.md
# Status Flag Output Multiplexer

This block drives a small set of status output pins. Each pin has its own 7-bit control word. The word picks which internal indications show on that pin. Those indications are:

- three reference-monitor flags (loss of reference, out of limits, reference invalid), which exist separately for each of two references;
- three global flags (phase lock, frequency lock, interrupt request).

A pin takes its monitor flags from exactly one of the two references. It combines the enabled flags with a logical OR, and presents the result through an output register. The register keeps combinational glitches off the pins.

Control words are loaded through a simple addressed write port. That port is fed by the device's serial register interface. A separate drive-enable input comes from the power-up strap logic. While it is low, every pin driver is released, so the pins can act as inputs for the strap sampling elsewhere in the chip.

Top module: `status_pin_mux`

## Requirements
- R1: After reset every control word is zero and every `status_out` bit is 0, whatever the flag inputs are.
- R2: A cycle with `cfg_we` high stores `cfg_wdata` as the control word of pin `cfg_addr` at that clock edge. The words of all other pins are left unchanged, and no word changes in a cycle without `cfg_we`.
- R3: Control word bit 0 picks the reference: 0 takes the monitor flags from index 0 of `ref_lor`/`ref_ool`/`ref_inv` (reference A), and 1 takes them from index 1 (reference B).
- R4: Control word bits 1, 2 and 3 enable loss of reference, out of limits and reference invalid of the selected reference. The flags of the other reference never affect the pin.
- R5: Control word bits 4, 5 and 6 enable `phase_lock`, `freq_lock` and `irq_flag`. These apply whichever reference is selected.
- R6: A pin is 1 when at least one enabled flag is 1, and 0 otherwise. For example, with both loss and out-of-limits enabled, either one alone sets the pin.
- R7: A pin whose bits 1 to 6 are all zero outputs 0 whatever the flags are.
- R8: `status_out` changes exactly one clock edge after the flag inputs change. A control write reaches the pin one edge after the word is stored.
- R9: `status_oe` is all zeros while `drv_en` is low and all ones while it is high, with no clock delay. `status_out` keeps tracking the flags either way.
- R10: When a control write and a flag change fall in the same cycle, the first edge combines the new flags with the old word. The next edge combines them with the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_addr | input | ADDR_W (2) | Pin index written |
| cfg_wdata | input | 7 | Control word: bit 0 reference select, bits 1..6 enables |
| ref_lor | input | 2 | Loss-of-reference flag per reference (bit 0 = A, bit 1 = B) |
| ref_ool | input | 2 | Out-of-limits flag per reference |
| ref_inv | input | 2 | Reference-invalid flag per reference |
| phase_lock | input | 1 | Phase lock flag |
| freq_lock | input | 1 | Frequency lock flag |
| irq_flag | input | 1 | Interrupt request flag |
| drv_en | input | 1 | Pin driver enable from power-up logic |
| status_out | output | NUM_PINS (4) | Registered pin values |
| status_oe | output | NUM_PINS (4) | Per-pin driver enable |

## Verification
A control word write and a flag change can land in the same clock cycle. Because the word and the pin are registered in series, the pin sees the two effects on different edges.

The bench provokes this on one pin. It writes a word that moves the enable from the interrupt flag to loss of reference, and in the same cycle raises the interrupt with loss of reference low. It then checks that the pin reads 1 after the first edge, since the old word is still in force, and 0 after the second edge, once the new word applies.

A random sweep then mixes writes and flag changes in the same cycles. It compares all pins against a model that tracks when each word takes effect.

// File: rtl/spm_pkg.sv
package spm_pkg;

    // Number of flag enables in a control word, plus one reference-select bit.
    localparam int FLAG_CNT = 6;
    localparam int CFG_W    = FLAG_CNT + 1;

    // Control word bit positions.
    localparam int SEL_BIT = 0;
    localparam int EN_LOR  = 1;
    localparam int EN_OOL  = 2;
    localparam int EN_INV  = 3;
    localparam int EN_PLK  = 4;
    localparam int EN_FLK  = 5;
    localparam int EN_IRQ  = 6;

    // Number of monitored references.
    localparam int NUM_REFS = 2;

    // Monitor flags of one reference.
    typedef struct packed {
        logic lor;
        logic ool;
        logic inv;
    } ref_flags_t;

    // Global flags.
    typedef struct packed {
        logic plk;
        logic flk;
        logic irq;
    } glob_flags_t;

endpackage

// File: rtl/spm_cfg_bank.sv
module spm_cfg_bank
    import spm_pkg::*;
#(
    parameter int NUM_PINS = 4,
    localparam int ADDR_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [CFG_W-1:0]                   wdata,
    output logic [NUM_PINS-1:0][CFG_W-1:0]     cfg_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0][CFG_W-1:0] words;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (we && (addr == ADDR_W'(i))) begin
                bank_d.words[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign cfg_o = bank_q.words;

    // R2: the addressed word takes the written data.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_o[$past(addr)] == $past(wdata)));

    // R2: without a write strobe, no word moves.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_o));

endmodule

// File: rtl/spm_pin_combiner.sv
module spm_pin_combiner
    import spm_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  ref_flags_t       ref_a,
    input  ref_flags_t       ref_b,
    input  glob_flags_t      glob,
    output logic             pin
);

    ref_flags_t chosen;
    logic [FLAG_CNT-1:0] flag_vec;
    logic [FLAG_CNT-1:0] en_vec;

    always_comb begin
        // Exactly one reference feeds the monitor indications.
        chosen   = cfg[SEL_BIT] ? ref_b : ref_a;
        flag_vec = '0;
        flag_vec[EN_LOR-1] = chosen.lor;
        flag_vec[EN_OOL-1] = chosen.ool;
        flag_vec[EN_INV-1] = chosen.inv;
        flag_vec[EN_PLK-1] = glob.plk;
        flag_vec[EN_FLK-1] = glob.flk;
        flag_vec[EN_IRQ-1] = glob.irq;
        en_vec   = cfg[CFG_W-1:1];
        pin      = |(flag_vec & en_vec);
    end

endmodule

// File: rtl/status_pin_mux.sv
module status_pin_mux
    import spm_pkg::*;
#(
    parameter int NUM_PINS = 4,
    localparam int ADDR_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic [NUM_REFS-1:0]  ref_lor,
    input  logic [NUM_REFS-1:0]  ref_ool,
    input  logic [NUM_REFS-1:0]  ref_inv,
    input  logic                 phase_lock,
    input  logic                 freq_lock,
    input  logic                 irq_flag,
    input  logic                 drv_en,
    output logic [NUM_PINS-1:0]  status_out,
    output logic [NUM_PINS-1:0]  status_oe
);

    logic [NUM_PINS-1:0][CFG_W-1:0] cfg_words;
    logic [NUM_PINS-1:0]            pin_raw;
    ref_flags_t                     flags_a, flags_b;
    glob_flags_t                    flags_g;

    typedef struct packed {
        logic [NUM_PINS-1:0] pins;
    } out_t;

    out_t out_d, out_q;

    spm_cfg_bank #(
        .NUM_PINS (NUM_PINS)
    ) cfg_bank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg_o (cfg_words)
    );

    always_comb begin
        flags_a = '{lor: ref_lor[0], ool: ref_ool[0], inv: ref_inv[0]};
        flags_b = '{lor: ref_lor[1], ool: ref_ool[1], inv: ref_inv[1]};
        flags_g = '{plk: phase_lock, flk: freq_lock, irq: irq_flag};
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        spm_pin_combiner comb_i (
            .cfg   (cfg_words[p]),
            .ref_a (flags_a),
            .ref_b (flags_b),
            .glob  (flags_g),
            .pin   (pin_raw[p])
        );

        // R7: a word with no enables yields a low pin one edge later.
        p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_words[p][CFG_W-1:1] == '0) |=> !status_out[p]);
    end

    always_comb begin
        out_d      = out_q;
        out_d.pins = pin_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign status_out = out_q.pins;
    assign status_oe  = {NUM_PINS{drv_en}};

    // R8: the pins show the combined value of the previous cycle.
    p_one_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_out == $past(pin_raw)));

endmodule

// File: tb/status_pin_mux_tb_top.sv
module status_pin_mux_tb_top;

    localparam int NP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [6:0] cfg_wdata = '0;
    logic [1:0] ref_lor = '0, ref_ool = '0, ref_inv = '0;
    logic       phase_lock = 1'b0, freq_lock = 1'b0, irq_flag = 1'b0;
    logic       drv_en = 1'b0;
    logic [NP-1:0] status_out, status_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [6:0] cfg_m [NP];

    always #5 clk = ~clk;

    status_pin_mux #(.NUM_PINS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ref_lor(ref_lor), .ref_ool(ref_ool),
        .ref_inv(ref_inv), .phase_lock(phase_lock), .freq_lock(freq_lock),
        .irq_flag(irq_flag), .drv_en(drv_en), .status_out(status_out),
        .status_oe(status_oe)
    );

    function automatic logic model(input logic [6:0] w);
        int r;
        r = int'(w[0]);
        return (w[1] & ref_lor[r]) | (w[2] & ref_ool[r]) | (w[3] & ref_inv[r])
             | (w[4] & phase_lock) | (w[5] & freq_lock) | (w[6] & irq_flag);
    endfunction

    task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [NP-1:0] model_all();
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++) v[i] = model(cfg_m[i]);
        return v;
    endfunction

    // Write a word at one edge; the pin reflects it after the next edge.
    task automatic write_cfg(input int pin, input logic [6:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(pin); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_m[pin] = w;
        @(negedge clk);
    endtask

    task automatic set_flags(input logic [1:0] l, o, v, input logic pl, fl, iq);
        ref_lor = l; ref_ool = o; ref_inv = v;
        phase_lock = pl; freq_lock = fl; irq_flag = iq;
    endtask

    task automatic settle_check(input string req);
        @(negedge clk);
        check(req, status_out, model_all());
    endtask

    task automatic t_reset();
        for (int i = 0; i < NP; i++) cfg_m[i] = '0;
        set_flags(2'b11, 2'b11, 2'b11, 1, 1, 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 during reset", status_out, '0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1 after reset", status_out, '0);
        check("R7 zero words with all flags", status_out, '0);
    endtask

    task automatic t_ref_select();
        set_flags('0, '0, '0, 0, 0, 0);
        write_cfg(0, 7'b0000010);           // ref A, LOR
        write_cfg(1, 7'b0000011);           // ref B, LOR
        set_flags(2'b10, '0, '0, 0, 0, 0);  // only B lost
        settle_check("R3 ref B flag");
        check("R4 A pin ignores B", {status_out[1], status_out[0]}, 2'b10);
        set_flags(2'b01, '0, '0, 0, 0, 0);
        settle_check("R3 ref A flag");
        check("R4 B pin ignores A", {status_out[1], status_out[0]}, 2'b01);
        write_cfg(0, 7'b0001000);           // A invalid only
        write_cfg(1, 7'b0001001);
        set_flags(2'b11, 2'b11, 2'b10, 0, 0, 0);
        settle_check("R4 invalid selected");
        check("R4 invalid values", {status_out[1], status_out[0]}, 2'b10);
    endtask

    task automatic t_global();
        write_cfg(2, 7'b0010001);           // phase lock, ref B
        write_cfg(3, 7'b1100000);           // freq lock | irq
        set_flags('0, '0, '0, 1, 0, 0);
        settle_check("R5 phase lock");
        check("R5 phase lock pin", status_out[3:2], 2'b01);
        set_flags('0, '0, '0, 0, 1, 0);
        settle_check("R5 freq lock");
        check("R5 freq lock pin", status_out[3:2], 2'b10);
        set_flags('0, '0, '0, 0, 0, 1);
        settle_check("R5 irq");
        check("R5 irq pin", status_out[3:2], 2'b10);
    endtask

    task automatic t_or();
        write_cfg(0, 7'b0000110);           // A: LOR | OOL
        set_flags(2'b01, 2'b00, '0, 0, 0, 0);
        settle_check("R6 lor alone");
        check("R6 lor alone pin", status_out[0], 1'b1);
        set_flags(2'b00, 2'b01, '0, 0, 0, 0);
        settle_check("R6 ool alone");
        check("R6 ool alone pin", status_out[0], 1'b1);
        set_flags(2'b10, 2'b10, 2'b11, 1, 1, 1);
        settle_check("R6 none enabled high");
        check("R6 none enabled pin", status_out[0], 1'b0);
        write_cfg(1, 7'b0000001);           // select bit only
        settle_check("R7 select bit only");
        check("R7 select only pin", status_out[1], 1'b0);
    endtask

    task automatic t_latency();
        write_cfg(3, 7'b1000000);
        set_flags('0, '0, '0, 0, 0, 0);
        @(negedge clk); @(negedge clk);
        irq_flag = 1'b1;
        #2;
        check("R8 before edge", status_out[3], 1'b0);
        @(negedge clk);
        check("R8 after one edge", status_out[3], 1'b1);
    endtask

    task automatic t_oe();
        drv_en = 1'b0;
        #1;
        check("R9 released", status_oe, '0);
        settle_check("R9 out tracks while released");
        drv_en = 1'b1;
        #1;
        check("R9 driven", status_oe, '1);
    endtask

    task automatic t_same_cycle();
        write_cfg(2, 7'b1000000);           // irq only
        set_flags('0, '0, '0, 0, 0, 0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 7'b0000010;
        irq_flag = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R10 first edge old word", status_out[2], 1'b1);
        @(negedge clk);
        cfg_m[2] = 7'b0000010;
        check("R10 second edge new word", status_out[2], 1'b0);
        check("R2 other pins kept", status_out, model_all());
    endtask

    task automatic t_sweep();
        logic [NP-1:0] pend;
        for (int n = 0; n < 300; n++) begin
            logic [6:0] w;
            int p;
            pend = model_all();
            p = int'($urandom_range(0, NP - 1));
            w = 7'($urandom);
            set_flags(2'($urandom), 2'($urandom), 2'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom));
            cfg_we = 1'($urandom);
            cfg_addr = 2'(p); cfg_wdata = w;
            pend = model_all();              // old words, new flags
            @(negedge clk);
            check("R10 sweep edge", status_out, pend);
            if (cfg_we) cfg_m[p] = w;
            cfg_we = 1'b0;
        end
        settle_check("R2 sweep final");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        drv_en = 1'b1;
        t_ref_select();
        t_global();
        t_or();
        t_latency();
        t_oe();
        t_same_cycle();
        t_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule